// File: doc/BRIEF.md
# Fetch-and-Add Combining Node

This node sits between two requesters and a single memory-side port and carries atomic fetch-and-add traffic. Each request names an address and an increment. Memory adds the increment to the word at that address and returns the value the word held before. When both requesters present the same address in the same cycle, the node sends one memory transaction whose increment is the sum of the two. When the single old value comes back, the node splits it into two distinct results, as if the two additions had been applied one after the other. When the addresses differ, the two requests go out one at a time and each reply returns unchanged to its owner.

Every forwarded request carries a tag. A small table indexed by that tag records whether the transaction was merged, which requester owns a single reply, and the increment of the requester that is treated as first. In a merged pair, input 0 always comes first, so its result is the old value and input 1 receives the old value plus input 0's increment. Replies may return in any order, because the tag identifies each one. Every port uses a valid/ready handshake. All additions wrap modulo 2^DW.

Top module: `faa_combine_node`

## Requirements
- R1: A request presented alone is forwarded with its address and increment unchanged. Its reply data is delivered unchanged on that requester's reply port and only there.
- R2: When both inputs are valid with equal addresses, one memory request is issued with increment (inc0 + inc1) mod 2^DW, and both inputs are accepted in that same cycle.
- R3: A merged reply carrying old value V delivers V on reply port 0 and (V + inc0) mod 2^DW on reply port 1.
- R4: When both inputs are valid with different addresses and no earlier deferral is pending, input 0 is forwarded first and input 1 is not accepted in that cycle. Input 1 is forwarded at a later issue.
- R5: After input 0 has been issued while input 1 waited, input 1 takes precedence at the next issue, even if input 0 presents a new request to a different address.
- R6: At most 2^TW transactions are outstanding. When all tags are in use, the memory request valid is low and no input is accepted.
- R7: Replies may return in any order. Each reply is matched to its transaction by the tag, which the node places on the request port and memory echoes back.
- R8: A merged reply is consumed from memory only when both halves have been delivered. Each half is delivered exactly once, even when the two reply ports become ready in different cycles.
- R9: A memory request that is valid but not accepted keeps its address, increment and tag unchanged until it is accepted, even if the other input becomes valid in the meantime.
- R10: During reset and directly after it, no request valid and no reply valid is asserted.
- R11: Under concurrent traffic from both inputs, for every address the final memory word equals its initial value plus the sum of all applied increments. The returned old values also form a serial chain of those increments.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req0_valid_i | input | 1 | Requester 0 request valid |
| req0_ready_o | output | 1 | Requester 0 request accepted |
| req0_addr_i | input | AW | Requester 0 address |
| req0_inc_i | input | DW | Requester 0 increment |
| req1_valid_i | input | 1 | Requester 1 request valid |
| req1_ready_o | output | 1 | Requester 1 request accepted |
| req1_addr_i | input | AW | Requester 1 address |
| req1_inc_i | input | DW | Requester 1 increment |
| mem_req_valid_o | output | 1 | Memory request valid |
| mem_req_ready_i | input | 1 | Memory request accepted |
| mem_req_addr_o | output | AW | Memory request address |
| mem_req_inc_o | output | DW | Memory request increment (summed when merged) |
| mem_req_tag_o | output | TW | Transaction tag |
| mem_rsp_valid_i | input | 1 | Memory reply valid |
| mem_rsp_ready_o | output | 1 | Memory reply consumed |
| mem_rsp_tag_i | input | TW | Tag echoed with the reply |
| mem_rsp_data_i | input | DW | Old memory value |
| rsp0_valid_o | output | 1 | Reply to requester 0 valid |
| rsp0_ready_i | input | 1 | Requester 0 takes its reply |
| rsp0_data_o | output | DW | Old value seen by requester 0 |
| rsp1_valid_o | output | 1 | Reply to requester 1 valid |
| rsp1_ready_i | input | 1 | Requester 1 takes its reply |
| rsp1_data_o | output | DW | Old value seen by requester 1 |

## Verification
The assertions assume well-behaved neighbours. A requester keeps its valid, address and increment steady until it is accepted. Memory holds a presented reply steady until it is consumed, and it only returns tags that are currently outstanding. The stimulus follows these rules. Directed tasks change inputs only after an acceptance, and the behavioural memory model draws replies strictly from its queue of accepted requests, which it reorders only between presentations. Randomised ready toggling in the concurrent test affects only the memory request ready and the reply-side readies, never the contents of a request that is waiting.

// File: rtl/faa_pkg.sv
package faa_pkg;
  typedef enum logic [1:0] {
    ISS_NONE  = 2'd0,
    ISS_P0    = 2'd1,
    ISS_P1    = 2'd2,
    ISS_MERGE = 2'd3
  } iss_kind_e;
endpackage

// File: rtl/faa_issue.sv
module faa_issue
  import faa_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req0_valid_i,
  input  logic [AW-1:0] req0_addr_i,
  input  logic [DW-1:0] req0_inc_i,
  input  logic          req1_valid_i,
  input  logic [AW-1:0] req1_addr_i,
  input  logic [DW-1:0] req1_inc_i,
  input  logic          slot_free_i,
  input  logic          mem_req_ready_i,
  output logic          mem_req_valid_o,
  output logic [AW-1:0] mem_req_addr_o,
  output logic [DW-1:0] mem_req_inc_o,
  output logic          req0_ready_o,
  output logic          req1_ready_o,
  output logic          fire_o,
  output iss_kind_e     kind_o
);
  logic      turn1_q, lock_q;
  iss_kind_e lock_kind_q, pick, kind;

  always_comb begin
    pick = ISS_NONE;
    if (req0_valid_i && req1_valid_i) begin
      if (req0_addr_i == req1_addr_i) pick = ISS_MERGE;
      else                            pick = turn1_q ? ISS_P1 : ISS_P0;
    end else if (req0_valid_i) begin
      pick = ISS_P0;
    end else if (req1_valid_i) begin
      pick = ISS_P1;
    end
  end

  // a stalled request keeps its selection so the outgoing beat stays stable
  assign kind            = lock_q ? lock_kind_q : pick;
  assign mem_req_valid_o = (kind != ISS_NONE) && slot_free_i;
  assign fire_o          = mem_req_valid_o && mem_req_ready_i;
  assign kind_o          = kind;
  assign mem_req_addr_o  = (kind == ISS_P1) ? req1_addr_i : req0_addr_i;
  assign mem_req_inc_o   = (kind == ISS_MERGE) ? req0_inc_i + req1_inc_i :
                           (kind == ISS_P1)    ? req1_inc_i : req0_inc_i;
  assign req0_ready_o    = fire_o && (kind == ISS_P0 || kind == ISS_MERGE);
  assign req1_ready_o    = fire_o && (kind == ISS_P1 || kind == ISS_MERGE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      turn1_q     <= 1'b0;
      lock_q      <= 1'b0;
      lock_kind_q <= ISS_NONE;
    end else begin
      lock_q      <= mem_req_valid_o && !mem_req_ready_i;
      lock_kind_q <= kind;
      if (fire_o) begin
        if (kind == ISS_P0 && req1_valid_i) turn1_q <= 1'b1;
        else if (kind != ISS_P0)            turn1_q <= 1'b0;
      end
    end
  end

  assert_merge_same_addr_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req0_ready_o && req1_ready_o) |-> (req0_addr_i == req1_addr_i));

  assert_one_at_a_time_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req0_valid_i && req1_valid_i && req0_addr_i != req1_addr_i)
      |-> !(req0_ready_o && req1_ready_o));

  assert_deferred_wins_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(req0_ready_o && req1_valid_i && !req1_ready_o) && req1_valid_i)
      |-> !(req0_ready_o && !req1_ready_o));

  assert_stall_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_valid_o && !mem_req_ready_i)
      |=> (mem_req_valid_o && $stable(mem_req_addr_o) && $stable(mem_req_inc_o)));
endmodule

// File: rtl/faa_pend_table.sv
module faa_pend_table #(
  parameter int DW = 32,
  parameter int TW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          alloc_i,
  input  logic          alloc_merged_i,
  input  logic          alloc_dest_i,
  input  logic [DW-1:0] alloc_first_inc_i,
  output logic          slot_free_o,
  output logic [TW-1:0] alloc_tag_o,
  input  logic          free_i,
  input  logic [TW-1:0] look_tag_i,
  output logic          look_merged_o,
  output logic          look_dest_o,
  output logic [DW-1:0] look_first_inc_o
);
  localparam int DEPTH = 1 << TW;

  logic [DEPTH-1:0] busy_q, merged_q, dest_q;
  logic [DW-1:0]    first_q [DEPTH];
  logic [TW-1:0]    ptr_q;

  assign slot_free_o      = !busy_q[ptr_q];
  assign alloc_tag_o      = ptr_q;
  assign look_merged_o    = merged_q[look_tag_i];
  assign look_dest_o      = dest_q[look_tag_i];
  assign look_first_inc_o = first_q[look_tag_i];

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    logic hit_alloc, hit_free;
    assign hit_alloc = alloc_i && (ptr_q == TW'(e));
    assign hit_free  = free_i && (look_tag_i == TW'(e));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        busy_q[e]   <= 1'b0;
        merged_q[e] <= 1'b0;
        dest_q[e]   <= 1'b0;
      end else if (hit_alloc) begin
        busy_q[e]   <= 1'b1;
        merged_q[e] <= alloc_merged_i;
        dest_q[e]   <= alloc_dest_i;
      end else if (hit_free) begin
        busy_q[e]   <= 1'b0;
      end
    end

    always_ff @(posedge clk_i) begin
      if (hit_alloc) first_q[e] <= alloc_first_inc_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ptr_q <= '0;
    else if (alloc_i) ptr_q <= ptr_q + 1'b1;
  end

  assert_alloc_free_slot_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_i |-> !busy_q[ptr_q]);

  assert_reply_tag_live_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    free_i |-> busy_q[look_tag_i]);
endmodule

// File: rtl/faa_reply_split.sv
module faa_reply_split #(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          mem_rsp_valid_i,
  input  logic [DW-1:0] mem_rsp_data_i,
  output logic          mem_rsp_ready_o,
  input  logic          merged_i,
  input  logic          dest_i,
  input  logic [DW-1:0] first_inc_i,
  output logic          free_o,
  output logic          rsp0_valid_o,
  input  logic          rsp0_ready_i,
  output logic [DW-1:0] rsp0_data_o,
  output logic          rsp1_valid_o,
  input  logic          rsp1_ready_i,
  output logic [DW-1:0] rsp1_data_o
);
  logic want0, want1, done0_q, done1_q;

  assign want0 = merged_i || !dest_i;
  assign want1 = merged_i ||  dest_i;

  assign rsp0_valid_o = mem_rsp_valid_i && want0 && !done0_q;
  assign rsp1_valid_o = mem_rsp_valid_i && want1 && !done1_q;
  assign rsp0_data_o  = mem_rsp_data_i;
  assign rsp1_data_o  = merged_i ? mem_rsp_data_i + first_inc_i : mem_rsp_data_i;

  assign mem_rsp_ready_o = (!want0 || done0_q || rsp0_ready_i) &&
                           (!want1 || done1_q || rsp1_ready_i);
  assign free_o          = mem_rsp_valid_i && mem_rsp_ready_o;

  // remember halves already delivered while the other half waits
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done0_q <= 1'b0;
      done1_q <= 1'b0;
    end else if (free_o) begin
      done0_q <= 1'b0;
      done1_q <= 1'b0;
    end else begin
      if (rsp0_valid_o && rsp0_ready_i) done0_q <= 1'b1;
      if (rsp1_valid_o && rsp1_ready_i) done1_q <= 1'b1;
    end
  end

  assert_once_port0_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp0_valid_o && rsp0_ready_i && !mem_rsp_ready_o) |=> !rsp0_valid_o);

  assert_once_port1_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp1_valid_o && rsp1_ready_i && !mem_rsp_ready_o) |=> !rsp1_valid_o);

  assert_pair_only_merged_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp0_valid_o && rsp1_valid_o) |-> merged_i);

  assert_reply_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp0_valid_o && !rsp0_ready_i && !mem_rsp_ready_o)
      |=> (rsp0_valid_o && $stable(rsp0_data_o)));
endmodule

// File: rtl/faa_combine_node.sv
module faa_combine_node
  import faa_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 32,
  parameter int TW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req0_valid_i,
  output logic          req0_ready_o,
  input  logic [AW-1:0] req0_addr_i,
  input  logic [DW-1:0] req0_inc_i,
  input  logic          req1_valid_i,
  output logic          req1_ready_o,
  input  logic [AW-1:0] req1_addr_i,
  input  logic [DW-1:0] req1_inc_i,
  output logic          mem_req_valid_o,
  input  logic          mem_req_ready_i,
  output logic [AW-1:0] mem_req_addr_o,
  output logic [DW-1:0] mem_req_inc_o,
  output logic [TW-1:0] mem_req_tag_o,
  input  logic          mem_rsp_valid_i,
  output logic          mem_rsp_ready_o,
  input  logic [TW-1:0] mem_rsp_tag_i,
  input  logic [DW-1:0] mem_rsp_data_i,
  output logic          rsp0_valid_o,
  input  logic          rsp0_ready_i,
  output logic [DW-1:0] rsp0_data_o,
  output logic          rsp1_valid_o,
  input  logic          rsp1_ready_i,
  output logic [DW-1:0] rsp1_data_o
);
  logic          slot_free, iss_fire, rsp_free;
  logic          look_merged, look_dest;
  logic [DW-1:0] look_first_inc;
  iss_kind_e     iss_kind;

  faa_issue #(.AW(AW), .DW(DW)) u_issue (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .req0_valid_i    (req0_valid_i),
    .req0_addr_i     (req0_addr_i),
    .req0_inc_i      (req0_inc_i),
    .req1_valid_i    (req1_valid_i),
    .req1_addr_i     (req1_addr_i),
    .req1_inc_i      (req1_inc_i),
    .slot_free_i     (slot_free),
    .mem_req_ready_i (mem_req_ready_i),
    .mem_req_valid_o (mem_req_valid_o),
    .mem_req_addr_o  (mem_req_addr_o),
    .mem_req_inc_o   (mem_req_inc_o),
    .req0_ready_o    (req0_ready_o),
    .req1_ready_o    (req1_ready_o),
    .fire_o          (iss_fire),
    .kind_o          (iss_kind)
  );

  faa_pend_table #(.DW(DW), .TW(TW)) u_table (
    .clk_i             (clk_i),
    .rst_ni            (rst_ni),
    .alloc_i           (iss_fire),
    .alloc_merged_i    (iss_kind == ISS_MERGE),
    .alloc_dest_i      (iss_kind == ISS_P1),
    .alloc_first_inc_i (req0_inc_i),
    .slot_free_o       (slot_free),
    .alloc_tag_o       (mem_req_tag_o),
    .free_i            (rsp_free),
    .look_tag_i        (mem_rsp_tag_i),
    .look_merged_o     (look_merged),
    .look_dest_o       (look_dest),
    .look_first_inc_o  (look_first_inc)
  );

  faa_reply_split #(.DW(DW)) u_split (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .mem_rsp_valid_i (mem_rsp_valid_i),
    .mem_rsp_data_i  (mem_rsp_data_i),
    .mem_rsp_ready_o (mem_rsp_ready_o),
    .merged_i        (look_merged),
    .dest_i          (look_dest),
    .first_inc_i     (look_first_inc),
    .free_o          (rsp_free),
    .rsp0_valid_o    (rsp0_valid_o),
    .rsp0_ready_i    (rsp0_ready_i),
    .rsp0_data_o     (rsp0_data_o),
    .rsp1_valid_o    (rsp1_valid_o),
    .rsp1_ready_i    (rsp1_ready_i),
    .rsp1_data_o     (rsp1_data_o)
  );
endmodule

// File: tb/tb_faa_combine_node.sv
module tb_faa_combine_node;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int AW = 8;
  localparam int DW = 32;
  localparam int TW = 2;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic req0_valid = 0, req1_valid = 0, req0_ready, req1_ready;
  logic [AW-1:0] req0_addr = '0, req1_addr = '0, mem_req_addr;
  logic [DW-1:0] req0_inc = '0, req1_inc = '0, mem_req_inc;
  logic mem_req_valid, mem_req_ready = 1'b1;
  logic [TW-1:0] mem_req_tag, mem_rsp_tag = '0;
  logic mem_rsp_valid = 1'b0, mem_rsp_ready;
  logic [DW-1:0] mem_rsp_data = '0, rsp0_data, rsp1_data;
  logic rsp0_valid, rsp1_valid, rsp0_ready = 1'b1, rsp1_ready = 1'b1;

  int n_chk = 0, n_fail = 0, n0 = 0, n1 = 0, nlog = 0;
  bit rsp_en = 1'b1, pick_last = 1'b0, cur_last = 1'b0, done_flag = 1'b0;
  logic [DW-1:0] mem [1<<AW];
  logic [TW-1:0] qt[$];
  logic [DW-1:0] qd[$];
  logic [DW-1:0] got0 [512], got1 [512];
  logic [AW-1:0] iss0_a[$], iss1_a[$];
  logic [DW-1:0] iss0_i[$], iss1_i[$];
  logic [AW-1:0] la [256];
  logic [DW-1:0] li [256], lo [256];
  int unsigned seed = 32'h1234_5678;

  always #2.5 clk = ~clk;

  faa_combine_node #(.AW(AW), .DW(DW), .TW(TW)) dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .req0_valid_i(req0_valid), .req0_ready_o(req0_ready),
    .req0_addr_i(req0_addr), .req0_inc_i(req0_inc),
    .req1_valid_i(req1_valid), .req1_ready_o(req1_ready),
    .req1_addr_i(req1_addr), .req1_inc_i(req1_inc),
    .mem_req_valid_o(mem_req_valid), .mem_req_ready_i(mem_req_ready),
    .mem_req_addr_o(mem_req_addr), .mem_req_inc_o(mem_req_inc),
    .mem_req_tag_o(mem_req_tag),
    .mem_rsp_valid_i(mem_rsp_valid), .mem_rsp_ready_o(mem_rsp_ready),
    .mem_rsp_tag_i(mem_rsp_tag), .mem_rsp_data_i(mem_rsp_data),
    .rsp0_valid_o(rsp0_valid), .rsp0_ready_i(rsp0_ready), .rsp0_data_o(rsp0_data),
    .rsp1_valid_o(rsp1_valid), .rsp1_ready_i(rsp1_ready), .rsp1_data_o(rsp1_data)
  );

  function automatic int unsigned rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed >> 8;
  endfunction

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural memory, reply monitors and issue log
  always @(posedge clk) begin
    if (mem_req_valid && mem_req_ready) begin
      qt.push_back(mem_req_tag);
      qd.push_back(mem[mem_req_addr]);
      mem[mem_req_addr] = mem[mem_req_addr] + mem_req_inc;
    end
    if (mem_rsp_valid && mem_rsp_ready) begin
      if (cur_last) begin void'(qt.pop_back()); void'(qd.pop_back()); end
      else          begin void'(qt.pop_front()); void'(qd.pop_front()); end
    end
    if (req0_valid && req0_ready) begin iss0_a.push_back(req0_addr); iss0_i.push_back(req0_inc); end
    if (req1_valid && req1_ready) begin iss1_a.push_back(req1_addr); iss1_i.push_back(req1_inc); end
    if (rsp0_valid && rsp0_ready) begin
      got0[n0] = rsp0_data; n0++;
      if (iss0_a.size() > 0 && nlog < 256) begin
        la[nlog] = iss0_a.pop_front(); li[nlog] = iss0_i.pop_front(); lo[nlog] = rsp0_data; nlog++;
      end
    end
    if (rsp1_valid && rsp1_ready) begin
      got1[n1] = rsp1_data; n1++;
      if (iss1_a.size() > 0 && nlog < 256) begin
        la[nlog] = iss1_a.pop_front(); li[nlog] = iss1_i.pop_front(); lo[nlog] = rsp1_data; nlog++;
      end
    end
  end

  initial forever begin
    @(posedge clk); #1;
    if (rsp_en && qt.size() > 0) begin
      mem_rsp_valid = 1'b1;
      cur_last      = pick_last;
      if (pick_last) begin mem_rsp_tag = qt[$]; mem_rsp_data = qd[$]; end
      else           begin mem_rsp_tag = qt[0]; mem_rsp_data = qd[0]; end
    end else begin
      mem_rsp_valid = 1'b0;
    end
  end

  task automatic wait_rsp(input int e0, input int e1, input string req);
    for (int c = 0; c < 300 && !(n0 >= e0 && n1 >= e1); c++) @(negedge clk);
    chk(req, DW'(n0 >= e0 && n1 >= e1), 1);
  endtask

  // start and end at a negedge
  task automatic send(input bit p, input logic [AW-1:0] a, input logic [DW-1:0] i);
    bit ok;
    if (!p) begin req0_valid = 1; req0_addr = a; req0_inc = i; end
    else    begin req1_valid = 1; req1_addr = a; req1_inc = i; end
    do begin
      #1; ok = p ? req1_ready : req0_ready;
      if (!ok) @(negedge clk);
    end while (!ok);
    @(negedge clk);
    if (!p) req0_valid = 0; else req1_valid = 0;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    #1;
    chk("R10 req valid in reset", mem_req_valid, 0);
    chk("R10 rsp0 valid in reset", rsp0_valid, 0);
    chk("R10 rsp1 valid in reset", rsp1_valid, 0);
    @(negedge clk); rst_ni = 1;
    @(negedge clk); #1;
    chk("R10 req valid after reset", mem_req_valid, 0);
    chk("R10 rsp valid after reset", DW'(rsp0_valid | rsp1_valid), 0);
    @(negedge clk);
  endtask

  task automatic t_single();
    int b0 = n0, b1 = n1;
    mem[5] = 100; mem[6] = 50;
    req0_valid = 1; req0_addr = 5; req0_inc = 7;
    #1;
    chk("R1 single valid", mem_req_valid, 1);
    chk("R1 single addr", DW'(mem_req_addr), 5);
    chk("R1 single inc", mem_req_inc, 7);
    @(negedge clk); req0_valid = 0;
    wait_rsp(b0 + 1, b1, "R1 reply0 arrives");
    chk("R1 reply0 data", got0[b0], 100);
    chk("R1 mem after single", mem[5], 107);
    send(1, 6, 3);
    wait_rsp(b0 + 1, b1 + 1, "R1 reply1 arrives");
    chk("R1 reply1 data", got1[b1], 50);
    chk("R1 port0 untouched", DW'(n0), DW'(b0 + 1));
  endtask

  task automatic t_merge();
    int b0 = n0, b1 = n1;
    mem[10] = 1000;
    req0_valid = 1; req0_addr = 10; req0_inc = 5;
    req1_valid = 1; req1_addr = 10; req1_inc = 32'hFFFF_FFFF;
    #1;
    chk("R2 merged inc wraps", mem_req_inc, 4);
    chk("R2 both accepted", DW'(req0_ready & req1_ready), 1);
    @(negedge clk); req0_valid = 0; req1_valid = 0;
    #1; chk("R2 single transaction", mem_req_valid, 0);
    wait_rsp(b0 + 1, b1 + 1, "R3 merged replies");
    chk("R3 first gets old", got0[b0], 1000);
    chk("R3 second gets old+inc0", got1[b1], 1005);
    chk("R2 memory sum", mem[10], 1004);
  endtask

  task automatic t_split_hs();
    int b0 = n0, b1 = n1;
    mem[11] = 7; rsp1_ready = 0;
    req0_valid = 1; req0_addr = 11; req0_inc = 2;
    req1_valid = 1; req1_addr = 11; req1_inc = 3;
    @(negedge clk); req0_valid = 0; req1_valid = 0;
    wait_rsp(b0 + 1, b1, "R8 half0 arrives");
    repeat (3) @(negedge clk);
    #1;
    chk("R8 half0 once", DW'(n0), DW'(b0 + 1));
    chk("R8 reply held", mem_rsp_ready, 0);
    chk("R8 reply still valid", mem_rsp_valid, 1);
    @(negedge clk); rsp1_ready = 1;
    wait_rsp(b0 + 1, b1 + 1, "R8 half1 arrives");
    chk("R8 half0 data", got0[b0], 7);
    chk("R8 half1 data", got1[b1], 9);
    @(negedge clk); #1;
    chk("R8 reply consumed", DW'(qt.size()), 0);
    chk("R8 no repeat", DW'(n0), DW'(b0 + 1));
  endtask

  task automatic t_diff();
    int b0 = n0, b1 = n1;
    mem[1] = 11; mem[2] = 22;
    req0_valid = 1; req0_addr = 1; req0_inc = 1;
    req1_valid = 1; req1_addr = 2; req1_inc = 2;
    #1;
    chk("R4 first addr", DW'(mem_req_addr), 1);
    chk("R4 input0 taken", req0_ready, 1);
    chk("R4 input1 held", req1_ready, 0);
    @(negedge clk); req0_valid = 0;
    #1;
    chk("R4 second addr", DW'(mem_req_addr), 2);
    chk("R4 input1 taken", req1_ready, 1);
    @(negedge clk); req1_valid = 0;
    wait_rsp(b0 + 1, b1 + 1, "R4 replies");
    chk("R4 reply0", got0[b0], 11);
    chk("R4 reply1", got1[b1], 22);
  endtask

  task automatic t_fair();
    int b0 = n0, b1 = n1;
    req0_valid = 1; req0_addr = 3; req0_inc = 1;
    req1_valid = 1; req1_addr = 4; req1_inc = 1;
    #1; chk("R5 first goes input0", req0_ready, 1);
    @(negedge clk); req0_addr = 5;
    #1;
    chk("R5 deferred addr", DW'(mem_req_addr), 4);
    chk("R5 input1 preferred", req1_ready, 1);
    chk("R5 input0 waits", req0_ready, 0);
    @(negedge clk); req1_valid = 0;
    #1; chk("R5 then input0", DW'(mem_req_addr), 5);
    @(negedge clk); req0_valid = 0;
    wait_rsp(b0 + 2, b1 + 1, "R5 replies");
  endtask

  task automatic t_full();
    int b0 = n0;
    rsp_en = 0;
    for (int k = 0; k < 4; k++) begin
      mem[30 + k] = 0;
      req0_valid = 1; req0_addr = AW'(30 + k); req0_inc = 1;
      #1; chk("R6 tag available", req0_ready, 1);
      @(negedge clk);
    end
    mem[34] = 0; req0_addr = 34;
    #1;
    chk("R6 full no request", mem_req_valid, 0);
    chk("R6 full no accept", req0_ready, 0);
    @(negedge clk); rsp_en = 1;
    req0_valid = 0;
    send(0, 34, 1);
    wait_rsp(b0 + 5, n1, "R6 drain");
    chk("R6 late request applied", mem[34], 1);
  endtask

  task automatic t_ooo();
    int b0 = n0, b1 = n1;
    rsp_en = 0; pick_last = 1;
    mem[20] = 200; mem[21] = 210;
    req0_valid = 1; req0_addr = 20; req0_inc = 1;
    req1_valid = 1; req1_addr = 21; req1_inc = 1;
    @(negedge clk); req0_valid = 0;
    @(negedge clk); req1_valid = 0;
    repeat (2) @(negedge clk);
    rsp_en = 1;
    wait_rsp(b0, b1 + 1, "R7 later reply first");
    chk("R7 port0 not yet", DW'(n0), DW'(b0));
    chk("R7 reply1 by tag", got1[b1], 210);
    wait_rsp(b0 + 1, b1 + 1, "R7 earlier reply");
    chk("R7 reply0 by tag", got0[b0], 200);
    @(negedge clk); pick_last = 0;
  endtask

  task automatic t_stall();
    logic [TW-1:0] tg;
    int b0 = n0, b1 = n1;
    mem[40] = 400; mem_req_ready = 0;
    req0_valid = 1; req0_addr = 40; req0_inc = 4;
    #1; tg = mem_req_tag;
    chk("R9 stalled not accepted", req0_ready, 0);
    @(negedge clk);
    req1_valid = 1; req1_addr = 40; req1_inc = 8;
    #1;
    chk("R9 inc stable", mem_req_inc, 4);
    chk("R9 addr stable", DW'(mem_req_addr), 40);
    chk("R9 tag stable", DW'(mem_req_tag), DW'(tg));
    @(negedge clk); mem_req_ready = 1;
    #1;
    chk("R9 held beat taken", DW'({req0_ready, req1_ready}), 2);
    @(negedge clk); req0_valid = 0;
    #1; chk("R9 input1 next", req1_ready, 1);
    @(negedge clk); req1_valid = 0;
    wait_rsp(b0 + 1, b1 + 1, "R9 replies");
    chk("R9 reply0", got0[b0], 400);
    chk("R9 reply1", got1[b1], 404);
    chk("R9 memory", mem[40], 412);
  endtask

  task automatic drive_port(input bit p);
    for (int k = 0; k < 60; k++) begin
      int unsigned r = rnd();
      send(p, AW'(50 + (r % 4)), DW'(1 + ((r >> 4) % 15)));
    end
  endtask

  task automatic t_stress();
    int b0 = n0, b1 = n1;
    nlog = 0;
    iss0_a.delete(); iss0_i.delete(); iss1_a.delete(); iss1_i.delete();
    for (int a = 0; a < 4; a++) mem[50 + a] = DW'(256 * (a + 1));
    done_flag = 0;
    fork
      begin
        fork
          drive_port(0);
          drive_port(1);
        join
        done_flag = 1;
      end
      begin
        while (!done_flag) begin
          int unsigned r = rnd();
          rsp0_ready = (r % 4) != 0;
          rsp1_ready = ((r >> 3) % 4) != 0;
          mem_req_ready = ((r >> 6) % 4) != 0;
          @(negedge clk);
        end
      end
    join
    rsp0_ready = 1; rsp1_ready = 1; mem_req_ready = 1;
    wait_rsp(b0 + 60, b1 + 60, "R11 all replies");
    chk("R11 log count", DW'(nlog), 120);
    for (int a = 0; a < 4; a++) begin
      logic [DW-1:0] init = DW'(256 * (a + 1)), sum = 0;
      bit chain = 1;
      for (int e = 0; e < nlog; e++) begin
        if (la[e] == AW'(50 + a)) begin
          bit linked = (lo[e] == init);
          sum += li[e];
          for (int f = 0; f < nlog; f++)
            if (f != e && la[f] == la[e]) begin
              if (lo[f] + li[f] == lo[e]) linked = 1;
              if (lo[f] == lo[e]) chain = 0;
            end
          if (!linked) chain = 0;
        end
      end
      chk("R11 final memory", mem[50 + a], init + sum);
      chk("R11 serial chain", DW'(chain), 1);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(150000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    report();
  end

  initial begin
    t_reset();
    t_single();
    t_merge();
    t_split_hs();
    t_diff();
    t_fair();
    t_full();
    t_ooo();
    t_stall();
    t_stress();
    repeat (4) @(negedge clk);
    report();
  end
endmodule